// File: doc/BRIEF.md
# Virtual Supervisor Interrupt Injection Registers

This block holds two 64-bit machine-level registers. Machine software uses them to inject interrupts into the supervisor's pending view, including interrupts that the delegation mask does not route to the supervisor. The first register holds virtual pending bits. The second holds per-cause enables that decide whether each virtual pending bit reaches the supervisor.

The surrounding CSR file decodes the addresses and drives a two-bit selector. When the data port is 32 bits wide, the upper half of each register has its own selector value. The block takes the real machine pending vector and the delegation mask as inputs. For every cause it produces the supervisor-visible pending bit and a visibility bit.

Causes 1 and 9 are aliased while their enable bit is clear. In that state the virtual pending bit reads as the real pending bit. A write to that bit leaves on a write port aimed at the real pending register, and the bit stored here is left unchanged.

Top module: `vsi_inject`

## Requirements
- R1: After reset, the pending register reads zero and the enable register reads zero in every bit except the read-only-one bits. With the default parameters, the enable upper half reads 0x8000_0000.
- R2: Pending bits 1, 5, 9 and 13..63 are writable. Pending bits 0, 2-4, 6-8 and 10-12 always read zero.
- R3: Among enable bits 0..12, only bits 1 and 9 are always writable. Bit 5 is writable when the parameter STIP_WR is 1 and reads zero otherwise. All other bits in 0..12 read zero.
- R4: Each enable bit from 13 to 63 is writable if its HI_WR_MASK bit is set. Otherwise it reads one if its HI_RO1_MASK bit is set, and zero if not. The defaults make bits 13-15 and 32-47 writable and bit 63 read-only one.
- R5: For each cause i, s_pend_o[i] = deleg_i[i] ? real_pend_i[i] : (enable[i] & virtual_pending[i]).
- R6: For each cause i, s_vis_o[i] = deleg_i[i] | enable[i].
- R7: While enable bit 1 or 9 is zero, the pending bit with the same index reads real_pend_i. A pending write drives real_wr_o with that bit set in real_wr_mask_o and the written value in real_wr_data_o, and the stored bit keeps its value.
- R8: Selector encoding: 0 = pending bits 31:0, 1 = pending bits 63:32, 2 = enable bits 31:0, 3 = enable bits 63:32 (with a 32-bit port). A write through one half changes only that half.
- R9: A write is applied at the next rising clock edge. csr_rdata is combinational from the selector and the stored state, so it shows the old value until that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for the selected register half |
| csr_sel | input | 2 | Register/half selector (R8 encoding) |
| csr_wdata | input | CSR_W | Write data |
| csr_rdata | output | CSR_W | Read data of the selected half |
| real_pend_i | input | 64 | Real machine pending bits |
| deleg_i | input | 64 | Delegation mask |
| s_pend_o | output | 64 | Supervisor-visible pending bits |
| s_vis_o | output | 64 | Causes visible to the supervisor |
| real_wr_o | output | 1 | Aliased write to the real pending bits |
| real_wr_mask_o | output | 64 | Bits affected by the aliased write |
| real_wr_data_o | output | 64 | Values for the aliased write |

## Verification
The writable layout is found by writing all ones and then partial patterns to each half and reading them back. This separates writable bits, read-only-zero bits and read-only-one bits, and shows whether a write leaks into the other half. The supervisor pending vector is then checked under three patterns:
- no delegation with all real bits set, which shows only the enabled virtual bits;
- full delegation with no real bits set, which shows the delegated path wins;
- a mixed mask.

The alias test holds stored bits 1 and 9 at one while toggling the real bits. This separates the read-through and write-through paths from the stored value.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int unsigned NCAUSE = 64;

  typedef enum logic [1:0] {
    SEL_PEND_LO = 2'd0,
    SEL_PEND_HI = 2'd1,
    SEL_EN_LO   = 2'd2,
    SEL_EN_HI   = 2'd3
  } vsi_sel_e;

  // causes 0..12 follow fixed rules
  localparam logic [NCAUSE-1:0] LOW_FIELD  = 64'h0000_0000_0000_1FFF;
  localparam logic [NCAUSE-1:0] ALIAS_BITS = 64'h0000_0000_0000_0202;
  localparam logic [NCAUSE-1:0] TIMER_BIT  = 64'h0000_0000_0000_0020;
endpackage

// File: rtl/vsi_bitreg.sv
module vsi_bitreg #(
  parameter int unsigned W = 64,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  always_comb begin
    upd   = |(we & WMASK);
    q_nxt = ((q_r & ~we) | (d & we)) & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q = q_r;

  // R9
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we == '0) |=> $stable(q_r));

  // R9
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(we & WMASK)) |=> ((q_r & $past(we & WMASK)) == $past(d & we & WMASK)));
endmodule

// File: rtl/vsi_route.sv
module vsi_route #(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0] deleg,
  input  logic [N-1:0] real_pend,
  input  logic [N-1:0] en,
  input  logic [N-1:0] vpend,
  output logic [N-1:0] s_pend,
  output logic [N-1:0] s_vis
);
  for (genvar i = 0; i < N; i++) begin : g_cause
    assign s_pend[i] = deleg[i] ? real_pend[i] : (en[i] & vpend[i]);
    assign s_vis[i]  = deleg[i] | en[i];
  end
endmodule

// File: rtl/vsi_inject.sv
module vsi_inject
  import vsi_pkg::*;
#(
  parameter int unsigned  CSR_W       = 32,
  parameter bit           STIP_WR     = 1'b1,
  parameter logic [63:0]  HI_WR_MASK  = 64'h0000_FFFF_0000_E000,
  parameter logic [63:0]  HI_RO1_MASK = 64'h8000_0000_0000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [1:0]       csr_sel,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic [63:0]      real_pend_i,
  input  logic [63:0]      deleg_i,
  output logic [63:0]      s_pend_o,
  output logic [63:0]      s_vis_o,
  output logic             real_wr_o,
  output logic [63:0]      real_wr_mask_o,
  output logic [63:0]      real_wr_data_o
);
  localparam bit          SPLIT   = (CSR_W == 32);
  localparam logic [63:0] LO_HALF = SPLIT ? 64'h0000_0000_FFFF_FFFF : '1;
  localparam logic [63:0] HI_HALF = SPLIT ? 64'hFFFF_FFFF_0000_0000 : '0;
  localparam logic [63:0] PEND_WR = ~LOW_FIELD | ALIAS_BITS | TIMER_BIT;
  localparam logic [63:0] EN_WR   = (HI_WR_MASK & ~LOW_FIELD) | ALIAS_BITS
                                    | (STIP_WR ? TIMER_BIT : 64'h0);
  localparam logic [63:0] EN_RO1  = HI_RO1_MASK & ~LOW_FIELD & ~EN_WR;

  logic [63:0] wd64, half_mask, alias_act;
  logic [63:0] pend_q, en_q, pend_view, en_view, view;
  logic [63:0] pend_we, en_we;
  logic        wr_pend, wr_en, hi_sel;

  if (SPLIT) begin : g_split
    assign wd64      = {2{csr_wdata}};
    assign csr_rdata = hi_sel ? view[63:32] : view[31:0];
  end else begin : g_full
    assign wd64      = 64'(csr_wdata);
    assign csr_rdata = hi_sel ? '0 : view[CSR_W-1:0];
  end

  always_comb begin
    hi_sel    = csr_sel[0];
    wr_pend   = csr_we & ~csr_sel[1];
    wr_en     = csr_we &  csr_sel[1];
    half_mask = hi_sel ? HI_HALF : LO_HALF;
    en_view   = en_q | EN_RO1;
    alias_act = ALIAS_BITS & ~en_view;
    pend_view = (pend_q & ~alias_act) | (real_pend_i & alias_act);
    view      = csr_sel[1] ? en_view : pend_view;
    pend_we   = {64{wr_pend}} & half_mask & PEND_WR & ~alias_act;
    en_we     = {64{wr_en}} & half_mask & EN_WR;
    real_wr_mask_o = {64{wr_pend}} & half_mask & alias_act;
    real_wr_o      = |real_wr_mask_o;
    real_wr_data_o = wd64 & real_wr_mask_o;
  end

  vsi_bitreg #(.W(64), .WMASK(PEND_WR)) u_pend (
    .clk(clk), .rst_n(rst_n), .we(pend_we), .d(wd64), .q(pend_q)
  );

  vsi_bitreg #(.W(64), .WMASK(EN_WR)) u_en (
    .clk(clk), .rst_n(rst_n), .we(en_we), .d(wd64), .q(en_q)
  );

  vsi_route #(.N(NCAUSE)) u_route (
    .deleg(deleg_i), .real_pend(real_pend_i), .en(en_view),
    .vpend(pend_view), .s_pend(s_pend_o), .s_vis(s_vis_o)
  );

  // R2
  rsvd_pend_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_sel == SEL_PEND_LO) |-> ((csr_rdata[12:0] & 13'h1DDD) == '0));

  // R7
  alias_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    real_wr_o |-> (((real_wr_mask_o & en_view) == '0) && ((pend_we & real_wr_mask_o) == '0)));

  // R5
  undeleg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_pend_o & ~deleg_i & ~s_vis_o) == '0));
endmodule

// File: tb/vsi_inject_bench.sv
`timescale 1ns/1ps
module vsi_inject_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [63:0] real_pend = '0, deleg = '0;
  logic [63:0] s_pend, s_vis, rw_mask, rw_data;
  logic        rw_v;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  vsi_inject u_vsi_inject (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .real_pend_i(real_pend), .deleg_i(deleg),
    .s_pend_o(s_pend), .s_vis_o(s_vis),
    .real_wr_o(rw_v), .real_wr_mask_o(rw_mask), .real_wr_data_o(rw_data)
  );

  // {write, sel, wdata, expected readback}
  localparam logic [66:0] TBL [0:9] = '{
    {1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0000_E222},  // R3 R4 low enable
    {1'b1, 2'd3, 32'hFFFF_FFFF, 32'h8000_FFFF},  // R4 upper enable
    {1'b1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_E222},  // R2 low pending
    {1'b1, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R2 upper pending
    {1'b1, 2'd1, 32'h1234_5678, 32'h1234_5678},  // R8
    {1'b0, 2'd0, 32'h0000_0000, 32'hFFFF_E222},  // R8 low half untouched
    {1'b1, 2'd2, 32'h0000_2020, 32'h0000_2020},  // R3
    {1'b0, 2'd3, 32'h0000_0000, 32'h8000_FFFF},  // R8
    {1'b1, 2'd3, 32'h0000_0000, 32'h8000_0000},  // R4 read-only one
    {1'b1, 2'd0, 32'hA5A5_A5A5, 32'hA5A5_A020}   // R7 R2 aliased bits
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    csr_sel = s; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
    csr_sel = s;
    #1;
    chk(tag, {32'h0, csr_rdata}, {32'h0, exp});
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] en_v, vp_v, exp_sp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 32'h0, "R1 pend lo");
    rd(2'd1, 32'h0, "R1 pend hi");
    rd(2'd2, 32'h0, "R1 en lo");
    rd(2'd3, 32'h8000_0000, "R1 en hi");
    chk("R1 s_pend", s_pend, 64'h0);

    for (int k = 0; k < 10; k++) begin
      if (TBL[k][66]) wr(TBL[k][65:64], TBL[k][63:32]);
      rd(TBL[k][65:64], TBL[k][31:0], $sformatf("table row %0d", k));
    end

    // R7 read-through of real bits 1 and 9
    @(negedge clk);
    real_pend = 64'h202;
    rd(2'd0, 32'hA5A5_A222, "R7 read-through");
    // R7 write-through
    @(negedge clk);
    csr_sel = 2'd0; csr_wdata = 32'h0; csr_we = 1'b1;
    #1;
    chk("R7 real_wr_o", {63'h0, rw_v}, 64'h1);
    chk("R7 real_wr_mask_o", rw_mask, 64'h202);
    chk("R7 real_wr_data_o", rw_data, 64'h0);
    @(negedge clk);
    csr_we = 1'b0;
    rd(2'd0, 32'h0000_0202, "R7 after aliased write");
    real_pend = 64'h0;
    wr(2'd2, 32'h0000_0202);
    rd(2'd0, 32'h0000_0202, "R7 stored bits kept");

    // R9 timing: old value until the edge
    @(negedge clk);
    csr_sel = 2'd2; csr_wdata = 32'h0; csr_we = 1'b1;
    #1;
    chk("R9 before edge", {32'h0, csr_rdata}, 64'h202);
    @(negedge clk);
    csr_we = 1'b0;
    #1;
    chk("R9 after edge", {32'h0, csr_rdata}, 64'h0);

    // R5 R6 routing
    wr(2'd2, 32'h0000_2222);
    wr(2'd3, 32'h0000_0001);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h0000_0003);
    en_v = {32'h8000_0001, 32'h0000_2222};
    vp_v = {32'h0000_0003, 32'hFFFF_E222};
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: begin deleg = 64'h0; real_pend = '1; end
        1: begin deleg = '1; real_pend = 64'h0; end
        default: begin deleg = 64'h0000_0102_0000_2004; real_pend = 64'h0000_0100_0000_0004; end
      endcase
      #1;
      exp_sp = (deleg & real_pend) | (~deleg & en_v & vp_v);
      chk($sformatf("R5 pattern %0d", p), s_pend, exp_sp);
      chk($sformatf("R6 pattern %0d", p), s_vis, deleg | en_v);
      @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule